// File: doc/BRIEF.md
# Banked DRAM Command Sequencer

This block sits at the front of a memory controller. It takes single read or write requests, each naming a bank, a row, a column, a direction and a burst flag, and turns them into the command stream a multi-bank row/column memory expects. For every bank it remembers whether a row is open, and which one. From that it picks the shortest legal sequence: a column command alone, an activate followed by a column command, or a precharge, an activate and a column command.

A refresh scheduler runs beside the request path. It raises a refresh demand once per interval, where the interval is the retention window divided by the row count. When a demand is pending, the sequencer stops taking requests. It closes every open bank, lowest bank first, and then sends one refresh for the next row from a wrapping counter. The block issues at most one command per clock. Down-counters enforce the minimum spacings (activate to column, precharge to activate, refresh duration). A busy output tells the surrounding logic whether the sequencer is idle.

Top module: `dseq_sequencer`

## Requirements
- R1: Reset state:
  - all banks are closed;
  - the command bus shows NOP (code 0);
  - ready is high and busy is low;
  - no command is issued until a request arrives or a refresh falls due.
- R2: A request to a closed bank issues ACT (code 1) one cycle after acceptance, carrying the bank and the row on the address field. The column command follows exactly T_RCD cycles after the ACT.
- R3: A request to the row already open in its bank issues only the column command, one cycle after acceptance.
- R4: A request to a bank holding a different row issues three commands:
  - PRE (code 4) to that bank, one cycle after acceptance;
  - ACT exactly T_RP cycles after the PRE;
  - the column command exactly T_RCD cycles after the ACT.
- R5: The column command is RD (code 2) when the write flag is 0 and WR (code 3) when it is 1. It carries the request's bank, the column on the address field and the request's burst flag.
- R6: Banks keep their open rows independently. Activating or precharging one bank does not close the row open in another bank.
- R7: Refresh timing:
  - a refresh becomes due once every RETENTION_CYC/ROWS cycles (128 by default);
  - with no open banks, successive REF commands are exactly that far apart;
  - ready stays low from the moment a refresh is due until T_RFC cycles after its REF;
  - a held request is accepted in the first cycle after that.
- R8: Before refreshing, the block sends PRE to each open bank in ascending bank order, spaced T_RP apart. REF (code 5) follows T_RP after the last PRE. After the refresh every bank is closed, so the next access to any bank starts with ACT.
- R9: The address field of successive REF commands walks the rows 0, 1, ..., ROWS-1 and then wraps to 0.
- R10: busy is high while a request is being served or a refresh is pending or running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_bank_i | input | $clog2(BANKS) | Target bank |
| req_row_i | input | $clog2(ROWS) | Target row |
| req_col_i | input | $clog2(COLS) | Target column or burst start column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | Block transfer from the given column |
| cmd_o | output | 3 | Command code: NOP 0, ACT 1, RD 2, WR 3, PRE 4, REF 5 |
| cmd_bank_o | output | $clog2(BANKS) | Bank of the command |
| cmd_addr_o | output | max(row, column width) | Row for ACT and REF, column for RD and WR |
| cmd_burst_o | output | 1 | Burst flag of a column command |
| busy_o | output | 1 | Sequencer not idle or refresh pending |

## Verification
Several properties are checked on every cycle, whatever the traffic:
- a column command only ever targets an open bank holding the requested row;
- an ACT leaves its bank open on the row it carried;
- no bank is activated twice without a precharge in between;
- REF only goes out with every bank closed;
- ready is never high while a refresh is pending;
- ACT never directly follows PRE, and a column command never directly follows ACT.

The bench's scenarios are needed for the rest: the exact cycle of every command relative to request acceptance, the choice between hit, miss and closed-bank sequences, the refresh period, the ascending precharge order, the acceptance cycle after a refresh, and the wrapping of the refresh row counter.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dseq_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACCESS    = 2'd1,
        ST_REF_CLOSE = 2'd2,
        ST_REF_WAIT  = 2'd3
    } dseq_state_e;

endpackage

// File: rtl/dseq_refresh_timer.sv
module dseq_refresh_timer #(
    parameter int unsigned INTERVAL = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic due_o
);
    localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             due;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.due = 1'b0;
        if (st_q.cnt == '0) begin
            st_d.cnt = CNT_W'(INTERVAL - 1);
            st_d.due = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt <= CNT_W'(INTERVAL - 1);
            st_q.due <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign due_o = st_q.due;

    generate
        if (INTERVAL > 1) begin : g_due_chk
            // R7
            due_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                due_o |=> !due_o);
        end
    endgenerate

endmodule

// File: rtl/dseq_bank_table.sv
module dseq_bank_table #(
    parameter int unsigned BANKS = 4,
    parameter int unsigned ROW_W = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            open_en_i,
    input  logic                            close_en_i,
    input  logic                            close_all_i,
    input  logic [$clog2(BANKS)-1:0]        bank_i,
    input  logic [ROW_W-1:0]                row_i,
    output logic [BANKS-1:0]                open_o,
    output logic [BANKS-1:0][ROW_W-1:0]     rows_o
);
    localparam int unsigned BANK_W = $clog2(BANKS);

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic             valid_d, valid_q;
            logic [ROW_W-1:0] row_d, row_q;
            logic             hit_sel;

            assign hit_sel = (bank_i == BANK_W'(b));

            always_comb begin
                valid_d = valid_q;
                row_d   = row_q;
                if (close_all_i || (close_en_i && hit_sel)) begin
                    valid_d = 1'b0;
                end
                if (open_en_i && hit_sel) begin
                    valid_d = 1'b1;
                    row_d   = row_i;
                end
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    valid_q <= 1'b0;
                    row_q   <= '0;
                end else begin
                    valid_q <= valid_d;
                    row_q   <= row_d;
                end
            end

            assign open_o[b] = valid_q;
            assign rows_o[b] = row_q;

            // R2
            no_double_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (open_en_i && hit_sel) |-> !valid_q);
        end
    endgenerate

endmodule

// File: rtl/dseq_sequencer.sv
module dseq_sequencer
    import dseq_pkg::*;
#(
    parameter int unsigned BANKS         = 4,
    parameter int unsigned ROWS          = 16,
    parameter int unsigned COLS          = 16,
    parameter int unsigned T_RCD         = 2,
    parameter int unsigned T_RP          = 2,
    parameter int unsigned T_RFC         = 4,
    parameter int unsigned RETENTION_CYC = 2048
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 req_valid_i,
    output logic                                 req_ready_o,
    input  logic [$clog2(BANKS)-1:0]             req_bank_i,
    input  logic [$clog2(ROWS)-1:0]              req_row_i,
    input  logic [$clog2(COLS)-1:0]              req_col_i,
    input  logic                                 req_write_i,
    input  logic                                 req_burst_i,
    output logic [2:0]                           cmd_o,
    output logic [$clog2(BANKS)-1:0]             cmd_bank_o,
    output logic [(($clog2(ROWS) > $clog2(COLS)) ? $clog2(ROWS) : $clog2(COLS))-1:0] cmd_addr_o,
    output logic                                 cmd_burst_o,
    output logic                                 busy_o
);
    localparam int unsigned BANK_W       = $clog2(BANKS);
    localparam int unsigned ROW_W        = $clog2(ROWS);
    localparam int unsigned COL_W        = $clog2(COLS);
    localparam int unsigned ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int unsigned REF_INTERVAL = RETENTION_CYC / ROWS;
    localparam int unsigned MAX_A        = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int unsigned MAX_GAP      = (MAX_A > T_RFC) ? MAX_A : T_RFC;
    localparam int unsigned GAP_W        = $clog2(MAX_GAP + 1);

    typedef struct packed {
        dseq_state_e       state;
        logic [GAP_W-1:0]  gap;
        logic              ref_due;
        logic [ROW_W-1:0]  ref_row;
        logic [BANK_W-1:0] req_bank;
        logic [ROW_W-1:0]  req_row;
        logic [COL_W-1:0]  req_col;
        logic              req_write;
        logic              req_burst;
        dseq_cmd_e         cmd;
        logic [BANK_W-1:0] cmd_bank;
        logic [ADDR_W-1:0] cmd_addr;
        logic              cmd_burst;
    } seq_t;

    seq_t st_d, st_q;

    logic                          due_pulse;
    logic                          tbl_open_en;
    logic                          tbl_close_en;
    logic                          tbl_close_all;
    logic [BANK_W-1:0]             tbl_bank;
    logic [ROW_W-1:0]              tbl_row;
    logic [BANKS-1:0]              tbl_open;
    logic [BANKS-1:0][ROW_W-1:0]   tbl_rows;
    logic [BANK_W-1:0]             low_bank;

    dseq_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .due_o  (due_pulse)
    );

    dseq_bank_table #(
        .BANKS (BANKS),
        .ROW_W (ROW_W)
    ) u_banks (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .open_en_i   (tbl_open_en),
        .close_en_i  (tbl_close_en),
        .close_all_i (tbl_close_all),
        .bank_i      (tbl_bank),
        .row_i       (tbl_row),
        .open_o      (tbl_open),
        .rows_o      (tbl_rows)
    );

    // lowest-numbered open bank, closed first during refresh
    always_comb begin
        low_bank = '0;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (tbl_open[i]) low_bank = BANK_W'(i);
        end
    end

    assign req_ready_o = (st_q.state == ST_IDLE) && !st_q.ref_due;

    always_comb begin
        st_d           = st_q;
        st_d.cmd       = CMD_NOP;
        st_d.cmd_bank  = '0;
        st_d.cmd_addr  = '0;
        st_d.cmd_burst = 1'b0;
        tbl_open_en    = 1'b0;
        tbl_close_en   = 1'b0;
        tbl_close_all  = 1'b0;
        tbl_bank       = st_q.req_bank;
        tbl_row        = st_q.req_row;

        if (st_q.gap != '0) st_d.gap = st_q.gap - 1'b1;
        if (due_pulse)      st_d.ref_due = 1'b1;

        unique case (st_q.state)
            ST_IDLE: begin
                if (st_q.ref_due) begin
                    st_d.state = ST_REF_CLOSE;
                end else if (req_valid_i) begin
                    st_d.req_bank  = req_bank_i;
                    st_d.req_row   = req_row_i;
                    st_d.req_col   = req_col_i;
                    st_d.req_write = req_write_i;
                    st_d.req_burst = req_burst_i;
                    st_d.state     = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (st_q.gap == '0) begin
                    st_d.cmd_bank = st_q.req_bank;
                    if (!tbl_open[st_q.req_bank]) begin
                        st_d.cmd      = CMD_ACT;
                        st_d.cmd_addr = ADDR_W'(st_q.req_row);
                        tbl_open_en   = 1'b1;
                        st_d.gap      = GAP_W'(T_RCD - 1);
                    end else if (tbl_rows[st_q.req_bank] != st_q.req_row) begin
                        st_d.cmd      = CMD_PRE;
                        tbl_close_en  = 1'b1;
                        st_d.gap      = GAP_W'(T_RP - 1);
                    end else begin
                        st_d.cmd       = st_q.req_write ? CMD_WR : CMD_RD;
                        st_d.cmd_addr  = ADDR_W'(st_q.req_col);
                        st_d.cmd_burst = st_q.req_burst;
                        st_d.state     = ST_IDLE;
                    end
                end
            end
            ST_REF_CLOSE: begin
                if (st_q.gap == '0) begin
                    if (|tbl_open) begin
                        st_d.cmd      = CMD_PRE;
                        st_d.cmd_bank = low_bank;
                        tbl_bank      = low_bank;
                        tbl_close_en  = 1'b1;
                        st_d.gap      = GAP_W'(T_RP - 1);
                    end else begin
                        st_d.cmd      = CMD_REF;
                        st_d.cmd_addr = ADDR_W'(st_q.ref_row);
                        st_d.ref_row  = (st_q.ref_row == ROW_W'(ROWS - 1)) ?
                                        '0 : st_q.ref_row + 1'b1;
                        st_d.ref_due  = 1'b0;
                        tbl_close_all = 1'b1;
                        st_d.gap      = GAP_W'(T_RFC - 1);
                        st_d.state    = ST_REF_WAIT;
                    end
                end
            end
            ST_REF_WAIT: begin
                if (st_q.gap == '0) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o       = st_q.cmd;
    assign cmd_bank_o  = st_q.cmd_bank;
    assign cmd_addr_o  = st_q.cmd_addr;
    assign cmd_burst_o = st_q.cmd_burst;
    assign busy_o      = (st_q.state != ST_IDLE) || st_q.ref_due;

    // R3
    col_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cmd == CMD_RD || st_q.cmd == CMD_WR) |->
            (tbl_open[st_q.cmd_bank] && tbl_rows[st_q.cmd_bank] == st_q.req_row));

    // R2
    act_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cmd == CMD_ACT) |->
            (tbl_open[st_q.cmd_bank] && tbl_rows[st_q.cmd_bank] == st_q.cmd_addr[ROW_W-1:0]));

    // R8
    ref_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cmd == CMD_REF) |-> (tbl_open == '0) && ($past(tbl_open) == '0));

    // R7
    ref_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ref_due |-> !req_ready_o);

    generate
        if (T_RP > 1) begin : g_rp_chk
            // R4
            rp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.cmd == CMD_PRE) |=> (st_q.cmd != CMD_ACT && st_q.cmd != CMD_REF));
        end
        if (T_RCD > 1) begin : g_rcd_chk
            // R2
            rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.cmd == CMD_ACT) |=> (st_q.cmd != CMD_RD && st_q.cmd != CMD_WR));
        end
    endgenerate

endmodule

// File: tb/dseq_sequencer_tb.sv
module dseq_sequencer_tb;

    localparam int T_RCD    = 2;
    localparam int T_RP     = 2;
    localparam int T_RFC    = 4;
    localparam int ROWS     = 16;
    localparam int INTERVAL = 2048 / 16;

    localparam int C_ACT = 1;
    localparam int C_RD  = 2;
    localparam int C_WR  = 3;
    localparam int C_PRE = 4;
    localparam int C_REF = 5;

    localparam int K_HIT = 0;
    localparam int K_CLS = 1;
    localparam int K_MIS = 2;

    // {bank[1:0], row[3:0], col[3:0], write, burst, kind[1:0], other-bank-hit}
    localparam int NVEC = 10;
    localparam logic [14:0] VEC [NVEC] = '{
        {2'd0, 4'd3,  4'd5,  1'b0, 1'b0, 2'd1, 1'b0},
        {2'd0, 4'd3,  4'd6,  1'b1, 1'b1, 2'd0, 1'b0},
        {2'd1, 4'd7,  4'd1,  1'b0, 1'b1, 2'd1, 1'b0},
        {2'd0, 4'd3,  4'd2,  1'b0, 1'b0, 2'd0, 1'b1},
        {2'd0, 4'd9,  4'd4,  1'b1, 1'b0, 2'd2, 1'b0},
        {2'd1, 4'd7,  4'd15, 1'b1, 1'b0, 2'd0, 1'b1},
        {2'd2, 4'd0,  4'd0,  1'b0, 1'b0, 2'd1, 1'b0},
        {2'd3, 4'd15, 4'd9,  1'b1, 1'b1, 2'd1, 1'b0},
        {2'd2, 4'd1,  4'd3,  1'b0, 1'b0, 2'd2, 1'b0},
        {2'd3, 4'd15, 4'd0,  1'b0, 1'b0, 2'd0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [3:0] req_row = '0;
    logic [3:0] req_col = '0;
    logic       req_write = 1'b0;
    logic       req_burst = 1'b0;
    logic [2:0] cmd_o;
    logic [1:0] cmd_bank;
    logic [3:0] cmd_addr;
    logic       cmd_burst;
    logic       busy;

    always #10ns clk = ~clk;

    dseq_sequencer u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_bank_i  (req_bank),
        .req_row_i   (req_row),
        .req_col_i   (req_col),
        .req_write_i (req_write),
        .req_burst_i (req_burst),
        .cmd_o       (cmd_o),
        .cmd_bank_o  (cmd_bank),
        .cmd_addr_o  (cmd_addr),
        .cmd_burst_o (cmd_burst),
        .busy_o      (busy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int log_n = 0;
    int lg_code [256];
    int lg_bank [256];
    int lg_addr [256];
    int lg_bst  [256];
    int lg_cyc  [256];
    logic [14:0] v;
    int acc, s, k, t, r1, r2;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && cmd_o != 3'd0 && log_n < 256) begin
            lg_code[log_n] = int'(cmd_o);
            lg_bank[log_n] = int'(cmd_bank);
            lg_addr[log_n] = int'(cmd_addr);
            lg_bst[log_n]  = int'(cmd_burst);
            lg_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input int act, input int exp, input string tag);
        chk(act == exp, tag, act, exp);
    endtask

    function automatic int count_refs();
        int c = 0;
        for (int i = 0; i < log_n; i++) if (lg_code[i] == C_REF) c++;
        return c;
    endfunction

    function automatic int find_ref(input int n);
        int c = 0;
        for (int i = 0; i < log_n; i++) begin
            if (lg_code[i] == C_REF) begin
                if (c == n) return i;
                c++;
            end
        end
        return 0;
    endfunction

    task automatic wait_ref(input int n);
        do begin
            @(negedge clk);
            #1;
        end while (count_refs() < n);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // caller is at a negedge; returns the bench cycle of the accepting edge
    task automatic send(input int b, input int r, input int c, input bit we, input bit bu,
                        output int acc_cyc);
        bit got = 1'b0;
        req_bank  = 2'(b);
        req_row   = 4'(r);
        req_col   = 4'(c);
        req_write = we;
        req_burst = bu;
        req_valid = 1'b1;
        while (!got) begin
            got = req_ready;
            @(negedge clk);
        end
        req_valid = 1'b0;
        acc_cyc   = cyc;
        // R10 busy while serving
        chk_eq(int'(busy), 1, "R10 busy during access");
    endtask

    task automatic expect_cmd(input int idx, input int code, input int b, input int addr,
                              input int when, input string tag);
        chk_eq(lg_code[idx], code, tag);
        chk_eq(lg_bank[idx], b, tag);
        if (addr >= 0) chk_eq(lg_addr[idx], addr, tag);
        chk_eq(lg_cyc[idx], when, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_eq(int'(cmd_o), 0, "R1 command after reset");
        chk_eq(int'(req_ready), 1, "R1 ready after reset");
        chk_eq(int'(busy), 0, "R1 busy after reset");
        repeat (10) @(negedge clk);
        #1;
        chk_eq(log_n, 0, "R1 no spontaneous command");
        @(negedge clk);

        // R7 refresh period with all banks closed
        wait_ref(2);
        r1 = find_ref(0);
        r2 = find_ref(1);
        chk_eq(lg_cyc[r2] - lg_cyc[r1], INTERVAL, "R7 refresh period");
        wait_idle();

        // table of requests starting from all banks closed
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            s = log_n;
            send(int'(v[14:13]), int'(v[12:9]), int'(v[8:5]), v[4], v[3], acc);
            wait_idle();
            #1;
            k = s;
            t = acc + 1;
            if (int'(v[2:1]) == K_MIS) begin
                expect_cmd(k, C_PRE, int'(v[14:13]), -1, t, "R4 precharge on row miss");
                k++;
                t += T_RP;
            end
            if (int'(v[2:1]) != K_HIT) begin
                expect_cmd(k, C_ACT, int'(v[14:13]), int'(v[12:9]), t,
                           (int'(v[2:1]) == K_MIS) ? "R4 activate after precharge" :
                                                     "R2 activate closed bank");
                k++;
                t += T_RCD;
            end
            expect_cmd(k, v[4] ? C_WR : C_RD, int'(v[14:13]), int'(v[8:5]), t,
                       (int'(v[2:1]) == K_HIT) ? "R3 hit column only" : "R5 column command");
            chk_eq(lg_bst[k], int'(v[3]), "R5 burst flag");
            chk_eq(log_n, k + 1, "R3 no extra command");
            if (v[0]) chk_eq(lg_code[s], v[4] ? C_WR : C_RD, "R6 other bank kept open");
            @(negedge clk);
        end

        // refresh with all four banks open, request held meanwhile
        s = log_n;
        while (!busy) @(negedge clk);
        chk_eq(int'(req_ready), 0, "R7 ready low when refresh due");
        send(0, 9, 1, 1'b0, 1'b0, acc);
        wait_idle();
        #1;
        for (int b = 0; b < 4; b++) begin
            chk_eq(lg_code[s + b], C_PRE, "R8 precharge before refresh");
            chk_eq(lg_bank[s + b], b, "R8 ascending bank order");
            if (b > 0) chk_eq(lg_cyc[s + b] - lg_cyc[s + b - 1], T_RP, "R8 precharge spacing");
        end
        chk_eq(lg_code[s + 4], C_REF, "R8 refresh after precharges");
        chk_eq(lg_cyc[s + 4] - lg_cyc[s + 3], T_RP, "R8 refresh spacing");
        chk_eq(acc, lg_cyc[s + 4] + T_RFC + 1, "R7 acceptance after refresh");
        expect_cmd(s + 5, C_ACT, 0, 9, acc + 1, "R8 bank closed after refresh");
        expect_cmd(s + 6, C_RD, 0, 1, acc + 1 + T_RCD, "R5 read after reopen");

        // R9 refresh row walk and wrap
        wait_ref(ROWS + 2);
        for (int i = 0; i < ROWS + 2; i++) begin
            chk_eq(lg_addr[find_ref(i)], i % ROWS, "R9 refresh row sequence");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule